// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution Pulse-Width Modulator

This block drives one pulse-width modulated output from an 8-bit period timer. A clock divider lets the timer advance once every 4, 16 or 64 input clocks. Two sub-count bits below the timer give the comparator a 10-bit fine count, one fine step being 1, 4 or 16 input clocks. A period is (period value + 1) × 4 fine steps. The output goes high when a period starts and goes low once the fine count reaches the active duty value.

Software writes the period, the upper eight duty bits and a control byte through a small synchronous write port. The control byte holds the run bit, the prescale choice and the two low duty bits. The written duty value stays pending until the timer wraps. At the wrap it is copied into a shadow register that the comparator reads, so a running pulse is never cut short or stretched by a write. Clearing the run bit freezes the count and forces the output low. Setting it again resumes from the frozen count.

Top module: `pwm_dbuf_top`

## Requirements
- R1: A synchronous reset clears the output, the fine counter, the clock divider, the shadow duty and all written registers. After reset the output stays low, even once only the run bit has been set.
- R2: Writes decode wr_addr as follows: 0 = period value, 1 = duty bits 9:2, 2 = control, 3 = ignored. In the control byte, bit 0 is run, bits 2:1 select the fine-step length (00 = 1 clock, 01 = 4 clocks, 10 or 11 = 16 clocks) and bits 5:4 are duty bits 1:0.
- R3: While running, the output period is (period value + 1) × 4 × step-length input clocks.
- R4: For a duty D with 0 < D < 4 × (period value + 1), the output is high for D × step-length clocks in each period.
- R5: A duty of 0 keeps the output low for the whole period.
- R6: A duty of 4 × (period value + 1) or more is never matched, so the output stays high for the whole period.
- R7: A duty written during a period does not change that period's pulse. It takes effect at the next period start.
- R8: A duty write that is registered on the same clock edge as the timer wrap is not loaded at that wrap. The period that starts there keeps the old duty, and the new duty applies one period later.
- R9: Clearing the run bit drives the output low from the second clock after the write and freezes the fine counter. Setting it again resumes from the frozen count, so the next pulse starts only after the remaining steps of the interrupted period.
- R10: The output rises only at a period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_o | output | 1 | Modulated output |

## Verification
A software write to the duty register and the period wrap that loads the shadow can land on the same clock edge. The bench locks onto a rising edge of the output, which marks a wrap, and counts one full period of clocks. It then presents a new duty so that it is registered exactly on the next wrap edge. The pulse that starts there must still have the old width, and the pulse after it must have the new width. The same rising-edge reference is used to place mid-period writes and a run-bit pause at known fine counts.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

   localparam int PS_W = 4;

   typedef enum logic [1:0] {
      ADDR_PERIOD  = 2'd0,
      ADDR_DUTY_HI = 2'd1,
      ADDR_CTRL    = 2'd2,
      ADDR_NONE    = 2'd3
   } reg_addr_e;

   typedef enum logic [1:0] {
      STEP_1   = 2'b00,
      STEP_4   = 2'b01,
      STEP_16  = 2'b10,
      STEP_16B = 2'b11
   } step_sel_e;

   localparam int CTRL_RUN_BIT = 0;
   localparam int CTRL_PS_LSB  = 1;
   localparam int CTRL_LO_LSB  = 4;

   function automatic logic [PS_W-1:0] step_last(step_sel_e s);
      case (s)
         STEP_1:  step_last = 4'd0;
         STEP_4:  step_last = 4'd3;
         default: step_last = 4'd15;
      endcase
   endfunction

endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
   import pwm_dbuf_pkg::*;
#(
   parameter int TMR_W  = 8,
   parameter int FRAC_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [TMR_W-1:0]  wr_data,
   output logic [TMR_W-1:0]  period_q,
   output logic [TMR_W-1:0]  duty_hi_q,
   output logic [FRAC_W-1:0] duty_lo_q,
   output logic              run_q,
   output step_sel_e         step_sel_q
);

   if (TMR_W < CTRL_LO_LSB + FRAC_W) begin : g_bad_width
      $error("TMR_W too narrow for the control byte layout");
   end

   reg_addr_e addr;
   assign addr = reg_addr_e'(wr_addr);

   always_ff @(posedge clk) begin
      if (rst) begin
         period_q   <= '0;
         duty_hi_q  <= '0;
         duty_lo_q  <= '0;
         run_q      <= 1'b0;
         step_sel_q <= STEP_1;
      end else if (wr_en) begin
         case (addr)
            ADDR_PERIOD:  period_q  <= wr_data;
            ADDR_DUTY_HI: duty_hi_q <= wr_data;
            ADDR_CTRL: begin
               run_q      <= wr_data[CTRL_RUN_BIT];
               step_sel_q <= step_sel_e'(wr_data[CTRL_PS_LSB +: 2]);
               duty_lo_q  <= wr_data[CTRL_LO_LSB +: FRAC_W];
            end
            default: ;
         endcase
      end
   end

   logic unused_ctrl_bits;
   assign unused_ctrl_bits = ^wr_data;

endmodule

// File: rtl/pwm_dbuf_step.sv
module pwm_dbuf_step
   import pwm_dbuf_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      run,
   input  step_sel_e step_sel,
   output logic      step
);

   logic [PS_W-1:0] div_q;
   logic [PS_W-1:0] last;

   assign last = step_last(step_sel);
   assign step = run && (div_q == last);

   always_ff @(posedge clk) begin
      if (rst)       div_q <= '0;
      else if (step) div_q <= '0;
      else if (run)  div_q <= div_q + 1'b1;
   end

   assert_div_frozen_R9: assert property (@(posedge clk) disable iff (rst)
      !run |=> $stable(div_q));

endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer #(
   parameter int TMR_W  = 8,
   parameter int FRAC_W = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    step,
   input  logic [TMR_W-1:0]        period,
   output logic                    wrap,
   output logic [TMR_W+FRAC_W-1:0] fine_nxt
);

   localparam int FINE_W = TMR_W + FRAC_W;

   if (FRAC_W != 2) begin : g_bad_frac
      $error("FRAC_W must be 2: the fine count splits a step into quarters");
   end

   logic [FINE_W-1:0] fine_q;

   assign wrap     = step && (fine_q[FINE_W-1:FRAC_W] == period)
                          && (&fine_q[FRAC_W-1:0]);
   assign fine_nxt = wrap ? '0 : fine_q + 1'b1;

   always_ff @(posedge clk) begin
      if (rst)       fine_q <= '0;
      else if (step) fine_q <= fine_nxt;
   end

   assert_count_holds_R3: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(fine_q));

   assert_wrap_clears_R3: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (fine_q == '0));

endmodule

// File: rtl/pwm_dbuf_shadow.sv
module pwm_dbuf_shadow #(
   parameter int DUTY_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DUTY_W-1:0] pend,
   output logic [DUTY_W-1:0] act
);

   always_ff @(posedge clk) begin
      if (rst)       act <= '0;
      else if (load) act <= pend;
   end

   assert_shadow_held_R7: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(act));

endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top
   import pwm_dbuf_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic       pwm_o
);

   localparam int TMR_W  = 8;
   localparam int FRAC_W = 2;
   localparam int DUTY_W = TMR_W + FRAC_W;

   logic [TMR_W-1:0]  period_q;
   logic [TMR_W-1:0]  duty_hi_q;
   logic [FRAC_W-1:0] duty_lo_q;
   logic              run_q;
   step_sel_e         step_sel_q;
   logic              step;
   logic              wrap;
   logic [DUTY_W-1:0] fine_nxt;
   logic [DUTY_W-1:0] pend;
   logic [DUTY_W-1:0] act;
   logic              out_q;

   pwm_dbuf_regs #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .period_q(period_q), .duty_hi_q(duty_hi_q), .duty_lo_q(duty_lo_q),
      .run_q(run_q), .step_sel_q(step_sel_q)
   );

   pwm_dbuf_step u_step (
      .clk(clk), .rst(rst), .run(run_q), .step_sel(step_sel_q), .step(step)
   );

   pwm_dbuf_timer #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_timer (
      .clk(clk), .rst(rst), .step(step), .period(period_q),
      .wrap(wrap), .fine_nxt(fine_nxt)
   );

   assign pend = {duty_hi_q, duty_lo_q};

   pwm_dbuf_shadow #(.DUTY_W(DUTY_W)) u_shadow (
      .clk(clk), .rst(rst), .load(wrap), .pend(pend), .act(act)
   );

   always_ff @(posedge clk) begin
      if (rst)                            out_q <= 1'b0;
      else if (!run_q)                    out_q <= 1'b0;
      else if (wrap)                      out_q <= (pend != '0);
      else if (step && fine_nxt == act)   out_q <= 1'b0;
   end

   assign pwm_o = out_q;

   assert_off_low_R9: assert property (@(posedge clk) disable iff (rst)
      !run_q |=> !pwm_o);

   assert_rise_at_start_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_o) |-> $past(wrap));

   assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (rst)
      (wrap && pend == '0) |=> !pwm_o);

   assert_no_step_no_fall_R4: assert property (@(posedge clk) disable iff (rst)
      (run_q && !step && pwm_o) |=> pwm_o);

endmodule

// File: tb/pwm_dbuf_top_bench.sv
module pwm_dbuf_top_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       pwm;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pwm_dbuf_top u_pwm_dbuf_top (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm)
   );

   // {period[7:0], duty[9:0], step_sel[1:0]}
   localparam logic [19:0] VEC [0:7] = '{
      {8'd3, 10'd5,  2'd0},
      {8'd3, 10'd16, 2'd0},
      {8'd3, 10'd0,  2'd0},
      {8'd2, 10'd7,  2'd1},
      {8'd1, 10'd3,  2'd2},
      {8'd0, 10'd1,  2'd0},
      {8'd5, 10'd30, 2'd1},
      {8'd7, 10'd17, 2'd3}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   function automatic logic [7:0] ctrl(input logic run, input logic [1:0] ps,
                                       input logic [1:0] lo);
      return {2'b00, lo, 1'b0, ps, run};
   endfunction

   task automatic configure(input logic [7:0] pr, input logic [9:0] duty,
                            input logic [1:0] ps);
      do_reset();
      wr(2'd0, pr);
      wr(2'd1, duty[9:2]);
      wr(2'd2, ctrl(1'b1, ps, duty[1:0]));
   endtask

   task automatic wait_rise();
      while (pwm) @(negedge clk);
      while (!pwm) @(negedge clk);
   endtask

   // called at the negedge where the output is first seen high
   task automatic pulse_len(output int n);
      n = 1;
      forever begin
         @(negedge clk);
         if (pwm) n++;
         else break;
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      @(negedge clk);
      do_reset();
      // R1: reset state and cleared registers
      check("R1 output after reset", int'(pwm), 0);
      wr(2'd2, ctrl(1'b1, 2'd0, 2'd0));
      n = 0;
      repeat (40) begin
         @(negedge clk);
         if (pwm) n++;
      end
      check("R1 run with cleared registers stays low", n, 0);

      // table walk: R3, R4, R5, R6
      foreach (VEC[i]) begin
         int pr, duty, s, p, hi, cnt;
         pr   = int'(VEC[i][19:12]);
         duty = int'(VEC[i][11:2]);
         s    = (VEC[i][1:0] == 2'd0) ? 1 : (VEC[i][1:0] == 2'd1) ? 4 : 16;
         p    = (pr + 1) * 4 * s;
         hi   = (duty >= 4 * (pr + 1)) ? p : duty * s;
         configure(VEC[i][19:12], VEC[i][11:2], VEC[i][1:0]);
         repeat (p + 2) @(negedge clk);
         cnt = 0;
         repeat (2 * p) begin
            @(negedge clk);
            if (pwm) cnt++;
         end
         if (duty == 0)
            check($sformatf("R5 vec%0d high clocks", i), cnt, 0);
         else if (hi == p)
            check($sformatf("R6 vec%0d high clocks", i), cnt, 2 * p);
         else begin
            check($sformatf("R4 vec%0d high clocks", i), cnt, 2 * hi);
            wait_rise();
            cnt = 0;
            do begin @(negedge clk); cnt++; end while (pwm);
            do begin @(negedge clk); cnt++; end while (!pwm);
            check($sformatf("R3 vec%0d period clocks", i), cnt, p);
         end
      end

      // R7: mid-period duty change keeps current pulse
      configure(8'd3, 10'd8, 2'd0);
      wait_rise();
      wait_rise();
      wr(2'd2, ctrl(1'b1, 2'd0, 2'd2));
      wr(2'd1, 8'd0);
      n = 3;
      forever begin
         @(negedge clk);
         if (pwm) n++;
         else break;
      end
      check("R7 pulse during write", n, 8);
      wait_rise();
      pulse_len(n);
      check("R7 pulse after next start", n, 2);

      // R2: address 3 ignored
      wr(2'd3, 8'hFF);
      wait_rise();
      pulse_len(n);
      check("R2 address 3 write ignored", n, 2);

      // R8: write registered on the wrap edge
      wr(2'd2, ctrl(1'b1, 2'd0, 2'd0));
      wr(2'd1, 8'd2);
      wait_rise();
      wait_rise();
      repeat (15) @(negedge clk);
      wr(2'd1, 8'd1);
      check("R10 output rises on wrap edge", int'(pwm), 1);
      pulse_len(n);
      check("R8 pulse starting at collision wrap", n, 8);
      wait_rise();
      pulse_len(n);
      check("R8 pulse one period later", n, 4);

      // R9: pause and resume from the frozen count
      wr(2'd1, 8'd2);
      wait_rise();
      wait_rise();
      wr(2'd2, ctrl(1'b0, 2'd0, 2'd0));
      check("R9 output one clock after stop write", int'(pwm), 1);
      n = 0;
      repeat (20) begin
         @(negedge clk);
         if (pwm) n++;
      end
      check("R9 output low while stopped", n, 0);
      wr(2'd2, ctrl(1'b1, 2'd0, 2'd0));
      n = 1;
      while (!pwm) begin
         @(negedge clk);
         n++;
      end
      check("R9 clocks from resume to next pulse", n, 16);
      pulse_len(n);
      check("R9 first pulse after resume", n, 8);

      do_reset();
      check("R1 output after second reset", int'(pwm), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule